// File: doc/BRIEF.md
# Multi-Mode PRG Bank Mapper

This block sits between a CPU address bus and a banked program ROM. It turns any CPU address from 0x6000 to 0xFFFF into an 8K-granular ROM bank number. It also raises a ROM-select when that address should be served from ROM. Software sets it up by writing two groups of four byte registers. The bank group holds bank numbers. The mode group holds the layout choice, the low-window enable and the outer block bits.

The three low bits of mode register 0 choose one of eight program layouts. Four of them keep a fixed last bank. The other four take the last bank from bank register 3. The CPU space at 0x8000 can be one 32K bank, two 16K halves or four 8K slots. When mode bit 7 is set, ROM is also mapped into 0x6000-0x7FFF. That low bank comes from bank register 3, scaled to the current bank size. Two bits of mode register 3 select a 512K outer block, which sits on top of every bank number.

Register writes are clocked. The bank output and the select are combinational functions of the stored registers and the present CPU address.

Top module: `prg_bank_mapper`

## Requirements
- R1: Layout codes 0 and 4 in mode register 0 bits [2:0] map 0x8000-0xFFFF as one 32K bank. The output's bits [5:2] are 0xF for code 0 and bank register 3 bits [3:0] for code 4. Bits [1:0] of the output are CPU address bits [14:13].
- R2: Layout codes 1 and 5 use two 16K halves. The 0x8000 half takes bank register 1 bits [4:0] as output bits [5:1]. The 0xC000 half takes 0x1F for code 1 and bank register 3 bits [4:0] for code 5. Output bit 0 is CPU address bit 13.
- R3: Layout codes 2, 3, 6 and 7 use four 8K slots. Slots 0x8000, 0xA000 and 0xC000 take bits [5:0] of bank registers 0, 1 and 2. Slot 0xE000 is 0x3F for codes 2 and 3, and bank register 3 bits [5:0] for codes 6 and 7.
- R4: With mode register 0 bit 7 set, an access in 0x6000-0x7FFF asserts ROM-select. Its bank bits [5:0] are {reg3[3:0],2'b11} in 32K layouts, {reg3[4:0],1'b1} in 16K layouts and reg3[5:0] in 8K layouts.
- R5: ROM-select is low, and the bank output is 0, for addresses below 0x6000. The same holds in 0x6000-0x7FFF while mode register 0 bit 7 is clear.
- R6: Bank output bits [7:6] equal mode register 3 bits [2:1] whenever ROM-select is high.
- R7: A write with CPU address bits [15:12] = 0x8 stores the data in the bank register picked by address bits [1:0]. With bits [15:12] = 0xD, the data goes to the mode register picked by address bits [1:0]. Writes anywhere else change no register.
- R8: Reset sets all four bank registers to 0xFF and all four mode registers to 0x00. After reset, 0x8000 therefore maps to bank 0x3C and 0xE000 to 0x3F.
- R9: A register write is visible on the bank output for accesses from the clock cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| bank_out | output | 8 | 8K ROM bank number for cpu_addr |
| rom_sel | output | 1 | High when cpu_addr is served from ROM |

## Verification
Two functions can act on the same cycle: a register update, and the translation of the address that follows it. A layout change can also flip the source of the last slot while the outer block bits stay in force. The bench writes a bank or mode register and reads through the affected window in the very next cycle. It expects the new mapping with no stale value. It also changes mode register 3 while an 8K layout is active and reads both a register-driven slot and a fixed slot. In each case it judges whether the outer bits and the slot source combine as the requirements give.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter logic [7:0] BANK_INIT = 8'hFF,
  parameter logic [7:0] MODE_INIT = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  output logic [7:0]  bank_out,
  output logic        rom_sel
);

  logic [7:0] bank_r [4];
  logic [7:0] mode_r [4];

  wire bank_hit = cpu_addr[15:12] == 4'h8;
  wire mode_hit = cpu_addr[15:12] == 4'hD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        bank_r[i] <= BANK_INIT;
        mode_r[i] <= MODE_INIT;
      end
    end else if (cpu_wr) begin
      if (bank_hit) bank_r[cpu_addr[1:0]] <= cpu_wdata;
      if (mode_hit) mode_r[cpu_addr[1:0]] <= cpu_wdata;
    end
  end

  wire [2:0] layout = mode_r[0][2:0];
  wire       low_en = mode_r[0][7];
  wire [1:0] outer  = mode_r[3][2:1];
  wire [1:0] slot   = cpu_addr[14:13];
  wire [7:0] r3     = bank_r[3];
  wire       in_hi  = cpu_addr[15];
  wire       in_low = cpu_addr[15:13] == 3'b011;

  logic [5:0] idx;

  always_comb begin
    case (layout)
      3'd0, 3'd4: begin
        if (in_low) idx = {r3[3:0], 2'b11};
        else        idx = {(layout[2] ? r3[3:0] : 4'hF), slot};
      end
      3'd1, 3'd5: begin
        if (in_low)        idx = {r3[4:0], 1'b1};
        else if (!slot[1]) idx = {bank_r[1][4:0], slot[0]};
        else               idx = {(layout[2] ? r3[4:0] : 5'h1F), slot[0]};
      end
      default: begin
        if (in_low)          idx = r3[5:0];
        else if (slot == 2'd3) idx = layout[2] ? r3[5:0] : 6'h3F;
        else                 idx = bank_r[slot][5:0];
      end
    endcase
  end

  assign rom_sel  = in_hi | (in_low & low_en);
  assign bank_out = rom_sel ? {outer, idx} : 8'h00;

  logic unused_bits;
  assign unused_bits = ^{mode_r[1], mode_r[2], mode_r[3], mode_r[0], cpu_addr[11:2],
                         bank_r[0][7:6], bank_r[1][7:6], bank_r[2][7:6]};

  AST_LOW_SPACE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> (!rom_sel && bank_out == 8'h00)); // R5

  AST_LAST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!layout[2] && cpu_addr[15:13] == 3'b111) |-> (bank_out[5:0] == 6'h3F)); // R3

  AST_OUTER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hi && $past(cpu_wr && mode_hit && cpu_addr[1:0] == 2'd3))
      |-> (bank_out[7:6] == $past(cpu_wdata[2:1]))); // R6

  AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && bank_hit && cpu_addr[1:0] == 2'd2) |=> (bank_r[2] == $past(cpu_wdata))); // R7

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (bank_r[0] == BANK_INIT && bank_r[3] == BANK_INIT && mode_r[0] == MODE_INIT)); // R8

endmodule

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [7:0]  bank_out;
  logic        rom_sel;

  prg_bank_mapper u_prg_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .bank_out(bank_out), .rom_sel(rom_sel)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  bank;
    logic        sel;
    string       tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] b, input logic s, input string t);
    item_t it;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = a;
    it.addr = a; it.bank = b; it.sel = s; it.tag = t;
    sb.push_back(it);
  endtask

  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        total++;
        if (bank_out !== it.bank || rom_sel !== it.sel) begin
          bad++;
          $display("FAIL %s addr=%h actual bank=%h sel=%b expected bank=%h sel=%b",
                   it.tag, it.addr, bank_out, rom_sel, it.bank, it.sel);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    rd(16'h8000, 8'h3C, 1'b1, "R8");
    rd(16'hE000, 8'h3F, 1'b1, "R8");
    rd(16'h6000, 8'h00, 1'b0, "R5");
    rd(16'h4020, 8'h00, 1'b0, "R5");
    // R7 bank writes, plus a write outside the bank range
    wr(16'h8000, 8'h05);
    wr(16'h8001, 8'h0A);
    wr(16'h8002, 8'h13);
    wr(16'h8003, 8'h27);
    wr(16'h9003, 8'h11);
    // R1 layout 4 from reg3 nibble (7); R9 visible next cycle
    wr(16'hD000, 8'h04);
    rd(16'h8000, 8'h1C, 1'b1, "R9");
    rd(16'hA000, 8'h1D, 1'b1, "R1");
    rd(16'hE000, 8'h1F, 1'b1, "R7");
    rd(16'h7000, 8'h00, 1'b0, "R5");
    // R4 low window in 32K layout
    wr(16'hD000, 8'h84);
    rd(16'h6000, 8'h1F, 1'b1, "R4");
    rd(16'h7FFF, 8'h1F, 1'b1, "R4");
    // R2 layout 1
    wr(16'hD000, 8'h81);
    rd(16'h8000, 8'h14, 1'b1, "R2");
    rd(16'hA000, 8'h15, 1'b1, "R2");
    rd(16'hC000, 8'h3E, 1'b1, "R2");
    rd(16'hE000, 8'h3F, 1'b1, "R2");
    rd(16'h6000, 8'h0F, 1'b1, "R4");
    // R2 layout 5
    wr(16'hD000, 8'h05);
    rd(16'hC000, 8'h0E, 1'b1, "R2");
    rd(16'hE000, 8'h0F, 1'b1, "R2");
    rd(16'h6000, 8'h00, 1'b0, "R5");
    // R3 layout 2
    wr(16'hD000, 8'h82);
    rd(16'h8000, 8'h05, 1'b1, "R3");
    rd(16'hA000, 8'h0A, 1'b1, "R3");
    rd(16'hC000, 8'h13, 1'b1, "R3");
    rd(16'hE000, 8'h3F, 1'b1, "R3");
    rd(16'h6000, 8'h27, 1'b1, "R4");
    // R3 layouts 7 and 3
    wr(16'hD000, 8'h87);
    rd(16'hE000, 8'h27, 1'b1, "R3");
    wr(16'hD000, 8'h03);
    rd(16'hE000, 8'h3F, 1'b1, "R3");
    // R6 outer block bits
    wr(16'hD003, 8'h06);
    rd(16'h8000, 8'hC5, 1'b1, "R6");
    rd(16'hE000, 8'hFF, 1'b1, "R6");
    wr(16'hD003, 8'h02);
    rd(16'h8000, 8'h45, 1'b1, "R6");
    wr(16'hD003, 8'h04);
    wr(16'hD000, 8'h86);
    rd(16'h6000, 8'hA7, 1'b1, "R6");
    // R7 write outside the mode range leaves mode register 0 alone
    wr(16'hC000, 8'h00);
    rd(16'hE000, 8'hA7, 1'b1, "R7");
    // R8 reset mid-run
    @(negedge clk);
    cpu_wr = 1'b0;
    rst_n = 1'b0;
    rd(16'h8000, 8'h3C, 1'b1, "R8");
    @(negedge clk);
    rst_n = 1'b1;
    rd(16'hA000, 8'h3D, 1'b1, "R8");
    rd(16'h6000, 8'h00, 1'b0, "R8");
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard actual=%0d left expected=0", sb.size());
    end
    finish_run();
  end
endmodule